// File: doc/BRIEF.md
# Source-Routed Transaction Sender with Path Failover

This block sits where a resource's outgoing bus-cycle transactions enter a switched fabric. Each request carries an address in the one system-wide address space. The sender compares that address with a small table of address windows. The winning window supplies a source route, which is a switching-command path that steers the packet hop by hop. The packet leaves with this path at its head, together with a slot tag, a retry flag, the address and the data word.

The sender keeps a copy of every transaction until a positive acknowledgement returns. Each window holds two disjoint routes. If the first attempt is not acknowledged before a programmable timeout, the sender resends the transaction at once on the second route. If the second attempt also times out, the slot is retired and a one-cycle fault pulse names the slot, so that an out-of-band recovery agent can act. Software or a management agent may rewrite the table at any time, for example after a component is fenced off or brought back. An acknowledgement carries the slot tag and echoes the retry flag of the attempt it answers. Stray acknowledgements are dropped and counted in a saturating error counter.

Each of the four slots is a small state machine:
- State names: FREE, WAIT_PRI, RESEND, WAIT_BAK.
- Transitions:
  - launch: FREE to WAIT_PRI.
  - ack accepted: WAIT_PRI to FREE, or WAIT_BAK to FREE.
  - first expiry: WAIT_PRI to RESEND.
  - resend issued: RESEND to WAIT_BAK.
  - final expiry with fault: WAIT_BAK to FREE.

Top module: `route_sender`

## Requirements
- R1: After reset `pkt_valid`, `req_err` and `fault` are 0, `err_count` is 0, and `req_ready` is 1. All table entries are invalid after reset.
- R2: An accepted request whose address lies in a valid window (base ≤ addr ≤ limit, both ends inclusive) produces one packet in the following cycle. That packet carries the primary path of the lowest-indexed matching valid entry, `pkt_retry`=0, and the request's address and data.
- R3: A table write takes effect for the next request. An entry whose valid bit is 0 never matches, even when its window contains the address.
- R4: An accepted request that matches no valid window raises `req_err` for exactly one cycle, in the following cycle. It emits no packet and occupies no slot.
- R5: A new transaction takes the lowest-numbered free slot as its tag (0 to 3). `req_ready` is 0 while all four slots are busy. It returns to 1 in the cycle after one of them is acknowledged.
- R6: An acknowledgement with `ack_retry`=0 for a slot waiting on its primary path frees the slot. No resend and no fault follow.
- R7: If no acknowledgement arrives, the transaction is resent with the backup path of its entry, `pkt_retry`=1, and the same tag, address and data. With timeout value L, this resend leaves L+2 cycles after the primary packet. An acknowledgement with `ack_retry`=1 then frees the slot without a fault.
- R8: If the backup attempt is also not acknowledged, `fault` pulses for one cycle, L+1 cycles after the resend, with `fault_tag` set to the slot. The slot then becomes free.
- R9: An acknowledgement is ignored, and `err_count` rises by one, in two cases: the tagged slot is free, or `ack_retry` does not match the attempt that slot is waiting on. An ignored acknowledgement does not stop the pending timeout, resend or fault.
- R10: A pending resend takes priority over new requests. `req_ready` is 0 in the cycle between the first expiry and the resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Outgoing transaction present |
| req_addr | input | ADDR_W (16) | Transaction address |
| req_data | input | DATA_W (16) | Transaction data word |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_err | output | 1 | No-destination error response pulse |
| pkt_valid | output | 1 | Packet on the output this cycle |
| pkt_path | output | PATH_W (8) | Switching-command path placed at the packet head |
| pkt_tag | output | TAG_W (2) | Slot tag of the packet |
| pkt_retry | output | 1 | 1 when the packet travels on the backup path |
| pkt_addr | output | ADDR_W (16) | Address carried by the packet |
| pkt_data | output | DATA_W (16) | Data carried by the packet |
| ack_valid | input | 1 | Acknowledgement present |
| ack_tag | input | TAG_W (2) | Slot tag being acknowledged |
| ack_retry | input | 1 | Retry flag echoed from the answered packet |
| tmo_limit | input | TMO_W (8) | Timeout value L in cycles |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W (3) | Entry written |
| tbl_base | input | ADDR_W (16) | Window low address |
| tbl_limit | input | ADDR_W (16) | Window high address |
| tbl_valid | input | 1 | Entry valid bit |
| tbl_pri | input | PATH_W (8) | Primary path |
| tbl_bak | input | PATH_W (8) | Disjoint backup path |
| fault | output | 1 | Out-of-band fault pulse |
| fault_tag | output | TAG_W (2) | Slot retired by the fault (lowest one if several at once) |
| err_count | output | ERR_W (8) | Saturating count of ignored acknowledgements |

## Verification
The lookup is tried with addresses at a window's lower and upper edges and inside two overlapping windows. It is also tried with an address covered only by an invalid entry and with an address outside every window. Together these separate an inclusive comparison from an exclusive one, priority by index from later-entry-wins, and a valid-bit check from none. The delivery side is tried with several acknowledgement patterns: a prompt acknowledgement, none at all, one echoing the wrong attempt in either phase, one for a free slot, and one answering the resend. These show whether the timer, the path switch, the fault escalation and the stray-acknowledgement filter each act on the right slot and in the right cycle. Filling all four slots and freeing one in the middle checks tag reuse and back-pressure.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
    typedef enum logic [1:0] {
        SL_FREE     = 2'd0,
        SL_WAIT_PRI = 2'd1,
        SL_RESEND   = 2'd2,
        SL_WAIT_BAK = 2'd3
    } slot_state_t;
endpackage

// File: rtl/rs_path_table.sv
`timescale 1ns/1ps
module rs_path_table #(
    parameter int ADDR_W  = 16,
    parameter int PATH_W  = 8,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_limit,
    input  logic              wr_valid,
    input  logic [PATH_W-1:0] wr_pri,
    input  logic [PATH_W-1:0] wr_bak,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic [PATH_W-1:0] pri,
    output logic [PATH_W-1:0] bak
);
    logic [ADDR_W-1:0] base_q  [ENTRIES];
    logic [ADDR_W-1:0] limit_q [ENTRIES];
    logic [PATH_W-1:0] pri_q   [ENTRIES];
    logic [PATH_W-1:0] bak_q   [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[wr_idx] <= wr_valid;
            base_q[wr_idx]  <= wr_base;
            limit_q[wr_idx] <= wr_limit;
            pri_q[wr_idx]   <= wr_pri;
            bak_q[wr_idx]   <= wr_bak;
        end
    end

    // Scan from the top index down so the lowest-index match is written last.
    always_comb begin
        hit = 1'b0;
        pri = '0;
        bak = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid_q[i] && lk_addr >= base_q[i] && lk_addr <= limit_q[i]) begin
                hit = 1'b1;
                pri = pri_q[i];
                bak = bak_q[i];
            end
        end
    end
endmodule

// File: rtl/rs_slot.sv
`timescale 1ns/1ps
module rs_slot
    import rs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int PATH_W = 8,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              resend_go,
    input  logic              ack_sel,
    input  logic              ack_retry,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [PATH_W-1:0] bak_in,
    output logic              free_o,
    output logic              resend_o,
    output logic              ack_ok_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [PATH_W-1:0] bak_o
);
    slot_state_t state, state_nx;
    logic [TMO_W-1:0] cnt;
    logic             expire;

    assign expire = (cnt >= tmo_limit);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SL_FREE;
        else        state <= state_nx;
    end

    // Acknowledgement acceptance and next state
    always_comb begin
        ack_ok_o = 1'b0;
        state_nx = state;
        unique case (state)
            SL_FREE:     if (launch) state_nx = SL_WAIT_PRI;
            SL_WAIT_PRI: begin
                ack_ok_o = ack_sel && !ack_retry;
                if (ack_ok_o)    state_nx = SL_FREE;
                else if (expire) state_nx = SL_RESEND;
            end
            SL_RESEND:   if (resend_go) state_nx = SL_WAIT_BAK;
            SL_WAIT_BAK: begin
                ack_ok_o = ack_sel && ack_retry;
                if (ack_ok_o || expire) state_nx = SL_FREE;
            end
            default:     state_nx = SL_FREE;
        endcase
    end

    // Outputs
    always_comb begin
        free_o   = (state == SL_FREE);
        resend_o = (state == SL_RESEND);
        fault_o  = (state == SL_WAIT_BAK) && expire && !ack_ok_o;
    end

    // Timer and held copy of the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state_nx != state) begin
            cnt <= '0;
        end else if (state == SL_WAIT_PRI || state == SL_WAIT_BAK) begin
            cnt <= cnt + 1'b1;
        end
        if (state == SL_FREE && launch) begin
            addr_o <= addr_in;
            data_o <= data_in;
            bak_o  <= bak_in;
        end
    end
endmodule

// File: rtl/route_sender.sv
`timescale 1ns/1ps
module route_sender #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int PATH_W  = 8,
    parameter int ENTRIES = 8,
    parameter int SLOTS   = 4,
    parameter int TMO_W   = 8,
    parameter int ERR_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              req_err,
    output logic              pkt_valid,
    output logic [PATH_W-1:0] pkt_path,
    output logic [TAG_W-1:0]  pkt_tag,
    output logic              pkt_retry,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic [DATA_W-1:0] pkt_data,
    input  logic              ack_valid,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic              ack_retry,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] tbl_limit,
    input  logic              tbl_valid,
    input  logic [PATH_W-1:0] tbl_pri,
    input  logic [PATH_W-1:0] tbl_bak,
    output logic              fault,
    output logic [TAG_W-1:0]  fault_tag,
    output logic [ERR_W-1:0]  err_count
);
    logic              hit;
    logic [PATH_W-1:0] hit_pri, hit_bak;
    logic [SLOTS-1:0]  s_free, s_resend, s_ack_ok, s_fault;
    logic [ADDR_W-1:0] s_addr [SLOTS];
    logic [DATA_W-1:0] s_data [SLOTS];
    logic [PATH_W-1:0] s_bak  [SLOTS];
    logic              free_any, rs_any, flt_any;
    logic [TAG_W-1:0]  free_idx, rs_idx, flt_idx;
    logic              accept, take_new, stray;

    rs_path_table #(.ADDR_W(ADDR_W), .PATH_W(PATH_W), .ENTRIES(ENTRIES)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .wr_idx(tbl_idx),
        .wr_base(tbl_base), .wr_limit(tbl_limit), .wr_valid(tbl_valid),
        .wr_pri(tbl_pri), .wr_bak(tbl_bak), .lk_addr(req_addr),
        .hit(hit), .pri(hit_pri), .bak(hit_bak)
    );

    // Lowest-index pick among free, resend-pending and faulting slots
    always_comb begin
        free_any = 1'b0; free_idx = '0;
        rs_any   = 1'b0; rs_idx   = '0;
        flt_any  = 1'b0; flt_idx  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (s_free[i])   begin free_any = 1'b1; free_idx = TAG_W'(i); end
            if (s_resend[i]) begin rs_any   = 1'b1; rs_idx   = TAG_W'(i); end
            if (s_fault[i])  begin flt_any  = 1'b1; flt_idx  = TAG_W'(i); end
        end
    end

    assign req_ready = free_any && !rs_any;
    assign accept    = req_valid && req_ready;
    assign take_new  = accept && hit;
    assign stray     = ack_valid && !s_ack_ok[ack_tag];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        rs_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PATH_W(PATH_W), .TMO_W(TMO_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .launch(take_new && free_idx == TAG_W'(g)),
            .resend_go(rs_any && rs_idx == TAG_W'(g)),
            .ack_sel(ack_valid && ack_tag == TAG_W'(g)),
            .ack_retry(ack_retry), .tmo_limit(tmo_limit),
            .addr_in(req_addr), .data_in(req_data), .bak_in(hit_bak),
            .free_o(s_free[g]), .resend_o(s_resend[g]), .ack_ok_o(s_ack_ok[g]),
            .fault_o(s_fault[g]), .addr_o(s_addr[g]), .data_o(s_data[g]), .bak_o(s_bak[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid <= 1'b0; pkt_path <= '0; pkt_tag <= '0; pkt_retry <= 1'b0;
            pkt_addr  <= '0;   pkt_data <= '0; req_err <= 1'b0;
            fault     <= 1'b0; fault_tag <= '0; err_count <= '0;
        end else begin
            pkt_valid <= rs_any || take_new;
            if (rs_any) begin
                pkt_tag   <= rs_idx;
                pkt_path  <= s_bak[rs_idx];
                pkt_addr  <= s_addr[rs_idx];
                pkt_data  <= s_data[rs_idx];
                pkt_retry <= 1'b1;
            end else if (take_new) begin
                pkt_tag   <= free_idx;
                pkt_path  <= hit_pri;
                pkt_addr  <= req_addr;
                pkt_data  <= req_data;
                pkt_retry <= 1'b0;
            end
            req_err <= accept && !hit;
            fault   <= flt_any;
            if (flt_any) fault_tag <= flt_idx;
            if (stray && err_count != '1) err_count <= err_count + 1'b1;
        end
    end
endmodule

// File: rtl/rs_checker.sv
`timescale 1ns/1ps
module rs_checker #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_err,
    input logic             pkt_valid,
    input logic             ack_valid,
    input logic [ERR_W-1:0] err_count
);
    a_r4_err_no_packet: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !pkt_valid);

    a_r2_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (pkt_valid || req_err));

    a_r9_err_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_count) |-> (err_count == ERR_W'($past(err_count) + 1'b1)));

    a_r9_err_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_count) |-> $past(ack_valid));
endmodule

bind route_sender rs_checker #(.ERR_W(ERR_W)) u_rs_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_err(req_err), .pkt_valid(pkt_valid), .ack_valid(ack_valid),
    .err_count(err_count)
);

// File: tb/route_sender_test.sv
`timescale 1ns/1ps
module route_sender_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0, req_data = '0;
    logic        req_ready, req_err, pkt_valid, pkt_retry, fault;
    logic [7:0]  pkt_path, err_count;
    logic [1:0]  pkt_tag, fault_tag;
    logic [15:0] pkt_addr, pkt_data;
    logic        ack_valid = 1'b0, ack_retry = 1'b0;
    logic [1:0]  ack_tag = '0;
    logic [7:0]  tmo_limit = 8'd200;
    logic        tbl_we = 1'b0, tbl_valid = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [15:0] tbl_base = '0, tbl_limit = '0;
    logic [7:0]  tbl_pri = '0, tbl_bak = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    route_sender uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready), .req_err(req_err),
        .pkt_valid(pkt_valid), .pkt_path(pkt_path), .pkt_tag(pkt_tag),
        .pkt_retry(pkt_retry), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
        .ack_valid(ack_valid), .ack_tag(ack_tag), .ack_retry(ack_retry),
        .tmo_limit(tmo_limit), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_base(tbl_base), .tbl_limit(tbl_limit), .tbl_valid(tbl_valid),
        .tbl_pri(tbl_pri), .tbl_bak(tbl_bak), .fault(fault),
        .fault_tag(fault_tag), .err_count(err_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_entry(input int idx, input logic [15:0] base, input logic [15:0] lim,
                               input logic vld, input logic [7:0] pri, input logic [7:0] bak);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_base = base; tbl_limit = lim;
        tbl_valid = vld; tbl_pri = pri; tbl_bak = bak;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Drives one request; returns with the following cycle's outputs visible.
    task automatic send(input logic [15:0] addr, input logic [15:0] data);
        @(negedge clk);
        for (int g = 0; g < 50 && !req_ready; g++) @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input logic [1:0] tag, input logic retry);
        @(negedge clk);
        ack_valid = 1'b1; ack_tag = tag; ack_retry = retry;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic wait_pkt(input int max, output int n);
        n = 0;
        for (int k = 1; k <= max; k++) begin
            @(negedge clk);
            if (pkt_valid) begin n = k; break; end
        end
    endtask

    task automatic wait_fault(input int max, output int n);
        n = 0;
        for (int k = 1; k <= max; k++) begin
            @(negedge clk);
            if (fault) begin n = k; break; end
        end
    endtask

    task automatic t_reset;
        check("R1 pkt_valid", pkt_valid, 0);
        check("R1 req_err", req_err, 0);
        check("R1 fault", fault, 0);
        check("R1 err_count", err_count, 0);
        check("R1 req_ready", req_ready, 1);
        send(16'h1000, 16'h0001);
        check("R1 empty table gives error", req_err, 1);
    endtask

    task automatic t_lookup;
        write_entry(0, 16'h1000, 16'h1FFF, 1'b1, 8'h11, 8'h91);
        write_entry(1, 16'h1800, 16'h2FFF, 1'b1, 8'h22, 8'hA2);
        write_entry(2, 16'h3000, 16'h3FFF, 1'b0, 8'h33, 8'hB3);
        write_entry(3, 16'h3000, 16'h3FFF, 1'b1, 8'h44, 8'hC4);
        tmo_limit = 8'd200;
        send(16'h1000, 16'hA001);
        check("R2 base edge valid", pkt_valid, 1);
        check("R2 base edge path", pkt_path, 8'h11);
        check("R2 tag", pkt_tag, 0);
        check("R2 retry flag", pkt_retry, 0);
        check("R2 addr", pkt_addr, 16'h1000);
        check("R2 data", pkt_data, 16'hA001);
        ack(2'd0, 1'b0);
        send(16'h1FFF, 16'hA002);
        check("R2 limit edge path", pkt_path, 8'h11);
        ack(2'd0, 1'b0);
        send(16'h1800, 16'hA003);
        check("R2 overlap lowest index", pkt_path, 8'h11);
        ack(2'd0, 1'b0);
        send(16'h2000, 16'hA004);
        check("R2 second window path", pkt_path, 8'h22);
        ack(2'd0, 1'b0);
        send(16'h3000, 16'hA005);
        check("R3 invalid entry skipped", pkt_path, 8'h44);
        ack(2'd0, 1'b0);
    endtask

    task automatic t_nomatch;
        send(16'h0500, 16'h0);
        check("R4 error pulse", req_err, 1);
        check("R4 no packet", pkt_valid, 0);
        @(negedge clk);
        check("R4 pulse one cycle", req_err, 0);
        send(16'h1000, 16'h0);
        check("R4 no slot consumed", pkt_tag, 0);
        ack(2'd0, 1'b0);
    endtask

    task automatic t_rewrite;
        write_entry(0, 16'h1000, 16'h1FFF, 1'b1, 8'h55, 8'h95);
        send(16'h1000, 16'h0);
        check("R3 rewritten path", pkt_path, 8'h55);
        ack(2'd0, 1'b0);
        write_entry(3, 16'h3000, 16'h3FFF, 1'b0, 8'h44, 8'hC4);
        send(16'h3000, 16'h0);
        check("R3 invalidated entry", req_err, 1);
        check("R3 invalidated no packet", pkt_valid, 0);
    endtask

    task automatic t_fill;
        logic [7:0] e0;
        e0 = err_count;
        for (int i = 0; i < 4; i++) begin
            send(16'h1000 + 16'(i), 16'(i));
            check("R5 tag order", pkt_tag, 32'(i));
        end
        @(negedge clk);
        check("R5 full not ready", req_ready, 0);
        ack(2'd2, 1'b0);
        check("R5 ready after ack", req_ready, 1);
        send(16'h1004, 16'h4);
        check("R5 reuse freed tag", pkt_tag, 2);
        for (int i = 0; i < 4; i++) ack(2'(i), 1'b0);
        check("R6 valid acks not counted", err_count, e0);
    endtask

    task automatic t_ack_ok;
        int n;
        tmo_limit = 8'd4;
        send(16'h2000, 16'h0);
        ack(pkt_tag, 1'b0);
        wait_pkt(15, n);
        check("R6 no resend after ack", n, 0);
        check("R6 no fault after ack", fault, 0);
    endtask

    task automatic t_retry;
        int n, k;
        logic [1:0] t;
        tmo_limit = 8'd4;
        send(16'h2000, 16'hBEEF);
        t = pkt_tag;
        check("R2 primary before retry", pkt_path, 8'h22);
        k = 0;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            if (c == 5) check("R10 ready low while resend pending", req_ready, 0);
            if (pkt_valid) begin k = c; break; end
        end
        check("R7 resend delay L+2", k, 6);
        check("R7 backup path", pkt_path, 8'hA2);
        check("R7 retry flag", pkt_retry, 1);
        check("R7 same tag", pkt_tag, t);
        check("R7 same addr", pkt_addr, 16'h2000);
        check("R7 same data", pkt_data, 16'hBEEF);
        wait_fault(20, n);
        check("R8 fault delay L+1", n, 5);
        check("R8 fault tag", fault_tag, t);
        @(negedge clk);
        check("R8 fault one cycle", fault, 0);
        check("R8 slot freed", req_ready, 1);
    endtask

    task automatic t_stray;
        int n;
        logic [7:0] e0;
        logic [1:0] t;
        tmo_limit = 8'd4;
        e0 = err_count;
        ack(2'd3, 1'b0);
        check("R9 ack on free slot counted", err_count, e0 + 8'd1);
        send(16'h2000, 16'h0);
        t = pkt_tag;
        ack(t, 1'b1);
        check("R9 wrong attempt counted", err_count, e0 + 8'd2);
        wait_pkt(20, n);
        check("R9 resend still happens", pkt_retry, 1);
        ack(t, 1'b0);
        check("R9 stale primary ack counted", err_count, e0 + 8'd3);
        wait_fault(20, n);
        check("R9 fault still raised", n != 0, 1);
        send(16'h2000, 16'h0);
        t = pkt_tag;
        wait_pkt(20, n);
        check("R7 resend before backup ack", pkt_retry, 1);
        ack(t, 1'b1);
        wait_fault(12, n);
        check("R7 backup ack stops fault", n, 0);
        check("R7 backup ack not counted", err_count, e0 + 8'd3);
    endtask

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lookup();
        t_nomatch();
        t_rewrite();
        t_fill();
        t_ack_ok();
        t_retry();
        t_stray();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule